// File: doc/BRIEF.md
# Replicated-Register Steering Target Resolver

Some control registers exist once per hardware unit (per cache bank, per memory slice, per subslice) but share a single address. A read must be pointed at one copy that is actually alive: neither fused off nor powered down. This block takes a 24-bit register offset and returns a group/instance pair that reaches a live copy. It decides which replication class the offset belongs to by searching per-class tables of inclusive address ranges. It then applies that class's rule to the fuse-derived enable masks.

Range tables are loaded through a simple write port before queries are issued. A query starts with a one-cycle strobe. The resolver then walks the tables one entry per clock, in a fixed class order. The first matching entry ends the walk. If nothing matches, a programmable default pair comes out instead. Results are registered, announced by a one-cycle done strobe, and held until the next result.

Top module: `steer_resolver`

## Requirements
- R1: An entry matches when its valid bit is set and `cfg_lo <= offset <= cfg_hi`, with both bounds included.
- R2: Entries are searched class by class in the order L3 bank (class code 0), memory slice (1), LNCF (2), subslice (3), instance-zero (4). Within a class, entries are searched from index 0 to 7. The first matching entry decides the class.
- R3: When no entry matches, `hit` is 0, `err` is 0, and `grp`/`inst` equal `dflt_grp`/`dflt_inst`.
- R4: L3 bank class: `grp` is 0 and `inst` is the lowest enabled bank index. Fuse bit i of `l3_fuse` enables banks 2i and 2i+1.
- R5: Memory slice class: `grp` is the lowest present slice index and `inst` is 0. Slice m is present if `mem_l3_en[m]` is set or any of subslices 4m to 4m+3 in `ss_en` is set.
- R6: LNCF class: `grp` is twice the lowest present memory slice index (slice presence as in R5) and `inst` is 0.
- R7: Subslice class: with d the lowest set bit of `ss_en`, `grp` = d / 4 and `inst` = d mod 4.
- R8: Instance-zero class: `grp` and `inst` are both 0 and `err` is 0.
- R9: If the mask that a class relies on is all zero (bank mask, slice presence mask or `ss_en`), `hit` is 1, `grp` and `inst` are 0, and `err` is 1.
- R10: The walk visits one entry per clock at linear position p = class*8 + index. `done` pulses exactly p+1 cycles after the start edge on a match at p, and 40 cycles after it when nothing matches. `hit`, `grp`, `inst` and `err` hold their values until the next `done`.
- R11: A `start` that arrives during a walk is ignored. The running query keeps its offset and produces one `done` only.
- R12: A `cfg_we` write stores lo, hi and the valid bit for entry (`cfg_cls`, `cfg_idx`). An entry written with the valid bit clear never matches. Reset clears every valid bit and sets all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Query strobe; offset sampled when accepted |
| offset | input | 24 | Register offset to resolve |
| cfg_we | input | 1 | Range-table write enable |
| cfg_cls | input | 3 | Class code of the entry written (0..4) |
| cfg_idx | input | 3 | Entry index within the class |
| cfg_valid | input | 1 | Valid bit stored with the entry |
| cfg_lo | input | 24 | Inclusive lower bound |
| cfg_hi | input | 24 | Inclusive upper bound |
| l3_fuse | input | 3 | Bank-pair enable fuse field |
| mem_l3_en | input | 4 | Per-memory-slice L3 enables |
| ss_en | input | 16 | Subslice enable mask |
| dflt_grp | input | 8 | Default group when nothing matches |
| dflt_inst | input | 8 | Default instance when nothing matches |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A range entry matched |
| grp | output | 8 | Resolved group ID |
| inst | output | 8 | Resolved instance ID |
| err | output | 1 | Matched class had an all-zero enable mask |

## Verification
The bench aims at both edges of every range and at the value just outside them. An off-by-one comparison would either miss the boundary offset or accept its neighbour. It sets up overlapping ranges in two classes, and two overlapping entries within one class, to catch a reversed search order that picks the later match. It exercises slice presence through subslices alone and through memory enables alone, bank-pair expansion, and the divide/modulo split of the subslice index, each of which yields a plainly wrong ID if mishandled. It also measures the done latency for early, late and absent matches, fires a second start mid-walk, and zeroes each mask to confirm the error path and the 0,0 target.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int NCLASS = 5;

  // Search order is the numeric order of these codes.
  typedef enum logic [2:0] {
    CL_L3BANK   = 3'd0,
    CL_MSLICE   = 3'd1,
    CL_LNCF     = 3'd2,
    CL_SUBSLICE = 3'd3,
    CL_INST0    = 3'd4
  } steer_class_e;

  // Index of the lowest set bit; 0 when the vector is empty.
  function automatic int lowest_one(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/steer_range_table.sv
module steer_range_table
  import steer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ENT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_cls,
  input  logic [ENT_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_lo,
  input  logic [ADDR_W-1:0] wr_hi,
  input  logic [2:0]        rd_cls,
  input  logic [ENT_W-1:0]  rd_idx,
  input  logic [ADDR_W-1:0] probe,
  output logic              hit_o
);
  localparam int DEPTH = NCLASS << ENT_W;
  localparam int SW    = 3 + ENT_W;

  logic [ADDR_W-1:0] lo_q [DEPTH];
  logic [ADDR_W-1:0] hi_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  logic [SW-1:0] wr_slot, rd_slot;
  logic          wr_ok;

  assign wr_slot = {wr_cls, wr_idx};
  assign rd_slot = {rd_cls, rd_idx};
  assign wr_ok   = wr_en && (int'(wr_cls) < NCLASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_ok) begin
      vld_q[wr_slot] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      lo_q[wr_slot] <= wr_lo;
      hi_q[wr_slot] <= wr_hi;
    end
  end

  assign hit_o = vld_q[rd_slot] && (lo_q[rd_slot] <= probe) && (probe <= hi_q[rd_slot]);

endmodule

// File: rtl/steer_walker.sv
module steer_walker
  import steer_pkg::*;
#(
  parameter int ENT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step_hit,
  output logic             busy,
  output logic             accept,
  output logic             step_last,
  output logic             finish,
  output logic [2:0]       cur_cls,
  output logic [ENT_W-1:0] cur_idx
);
  localparam int PW = 3 + ENT_W;
  localparam logic [PW-1:0] LAST = {3'(NCLASS - 1), {ENT_W{1'b1}}};

  logic [PW-1:0] ptr_q;

  assign accept    = start && !busy;
  assign step_last = (ptr_q == LAST);
  assign finish    = busy && (step_hit || step_last);
  assign cur_cls   = ptr_q[PW-1 -: 3];
  assign cur_idx   = ptr_q[ENT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ptr_q <= '0;
    end else if (!busy) begin
      ptr_q <= '0;
      if (start) busy <= 1'b1;
    end else if (finish) begin
      busy <= 1'b0;
    end else begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/steer_target_calc.sv
module steer_target_calc
  import steer_pkg::*;
#(
  parameter int ID_W       = 8,
  parameter int L3F_W      = 3,
  parameter int NMS        = 4,
  parameter int SS_PER_MS  = 4,
  parameter int SS_PER_GRP = 4
) (
  input  steer_class_e          cls,
  input  logic                  use_dflt,
  input  logic [L3F_W-1:0]      l3_fuse,
  input  logic [NMS-1:0]        mem_l3_en,
  input  logic [NMS*SS_PER_MS-1:0] ss_en,
  input  logic [ID_W-1:0]       dflt_grp,
  input  logic [ID_W-1:0]       dflt_inst,
  output logic [ID_W-1:0]       grp,
  output logic [ID_W-1:0]       inst,
  output logic                  err
);
  localparam int NBANK = 2 * L3F_W;

  logic [NBANK-1:0] bank_mask;
  logic [NMS-1:0]   ms_mask;
  int               bank_first, ms_first, ss_first;

  for (genvar i = 0; i < L3F_W; i++) begin : g_bank
    assign bank_mask[2*i +: 2] = {2{l3_fuse[i]}};
  end

  for (genvar m = 0; m < NMS; m++) begin : g_ms
    assign ms_mask[m] = mem_l3_en[m] | (|ss_en[m*SS_PER_MS +: SS_PER_MS]);
  end

  assign bank_first = lowest_one(64'(bank_mask));
  assign ms_first   = lowest_one(64'(ms_mask));
  assign ss_first   = lowest_one(64'(ss_en));

  always_comb begin
    grp  = '0;
    inst = '0;
    err  = 1'b0;
    if (use_dflt) begin
      grp  = dflt_grp;
      inst = dflt_inst;
    end else begin
      case (cls)
        CL_L3BANK: begin
          inst = ID_W'(bank_first);
          err  = (bank_mask == '0);
        end
        CL_MSLICE: begin
          grp = ID_W'(ms_first);
          err = (ms_mask == '0);
        end
        CL_LNCF: begin
          grp = ID_W'(ms_first << 1);
          err = (ms_mask == '0);
        end
        CL_SUBSLICE: begin
          grp  = ID_W'(ss_first / SS_PER_GRP);
          inst = ID_W'(ss_first % SS_PER_GRP);
          err  = (ss_en == '0);
        end
        default: begin
          grp  = '0;
          inst = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int ENT_W      = 3,
  parameter int ID_W       = 8,
  parameter int L3F_W      = 3,
  parameter int NMS        = 4,
  parameter int SS_PER_MS  = 4,
  parameter int SS_PER_GRP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        offset,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_cls,
  input  logic [ENT_W-1:0]         cfg_idx,
  input  logic                     cfg_valid,
  input  logic [ADDR_W-1:0]        cfg_lo,
  input  logic [ADDR_W-1:0]        cfg_hi,
  input  logic [L3F_W-1:0]         l3_fuse,
  input  logic [NMS-1:0]           mem_l3_en,
  input  logic [NMS*SS_PER_MS-1:0] ss_en,
  input  logic [ID_W-1:0]          dflt_grp,
  input  logic [ID_W-1:0]          dflt_inst,
  output logic                     done,
  output logic                     hit,
  output logic [ID_W-1:0]          grp,
  output logic [ID_W-1:0]          inst,
  output logic                     err
);
  logic              walk_busy, accept, step_hit, step_last, finish;
  logic [2:0]        cur_cls;
  logic [ENT_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] off_q;
  logic [ID_W-1:0]   calc_grp, calc_inst;
  logic              calc_err;
  steer_class_e      res_cls;

  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= '0;
    else if (accept) off_q <= offset;
  end

  steer_walker #(.ENT_W(ENT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .step_hit(step_hit),
    .busy(walk_busy), .accept(accept), .step_last(step_last), .finish(finish),
    .cur_cls(cur_cls), .cur_idx(cur_idx)
  );

  steer_range_table #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_cls(cfg_cls), .wr_idx(cfg_idx),
    .wr_valid(cfg_valid), .wr_lo(cfg_lo), .wr_hi(cfg_hi),
    .rd_cls(cur_cls), .rd_idx(cur_idx), .probe(off_q), .hit_o(step_hit)
  );

  steer_target_calc #(
    .ID_W(ID_W), .L3F_W(L3F_W), .NMS(NMS), .SS_PER_MS(SS_PER_MS), .SS_PER_GRP(SS_PER_GRP)
  ) u_calc (
    .cls(steer_class_e'(cur_cls)), .use_dflt(!step_hit), .l3_fuse(l3_fuse),
    .mem_l3_en(mem_l3_en), .ss_en(ss_en), .dflt_grp(dflt_grp), .dflt_inst(dflt_inst),
    .grp(calc_grp), .inst(calc_inst), .err(calc_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      hit     <= 1'b0;
      grp     <= '0;
      inst    <= '0;
      err     <= 1'b0;
      res_cls <= CL_L3BANK;
    end else begin
      done <= finish;
      if (finish) begin
        hit     <= step_hit;
        grp     <= calc_grp;
        inst    <= calc_inst;
        err     <= calc_err;
        res_cls <= steer_class_e'(cur_cls);
      end
    end
  end

endmodule

// File: rtl/steer_resolver_chk.sv
module steer_resolver_chk
  import steer_pkg::*;
#(
  parameter int ID_W       = 8,
  parameter int SS_PER_GRP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            hit,
  input logic            err,
  input logic [ID_W-1:0] grp,
  input logic [ID_W-1:0] inst,
  input logic [ID_W-1:0] dflt_grp,
  input logic [ID_W-1:0] dflt_inst,
  input steer_class_e    res_cls,
  input logic            walk_busy
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_from_walk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(walk_busy));

  a_r3_default_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (grp == $past(dflt_grp) && inst == $past(dflt_inst) && !err));

  a_r4_bank_group_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && res_cls == CL_L3BANK) |-> (grp == '0));

  a_r6_lncf_even: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && res_cls == CL_LNCF) |-> (grp[0] == 1'b0 && inst == '0));

  a_r7_inst_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && res_cls == CL_SUBSLICE) |-> (inst < ID_W'(SS_PER_GRP)));

  a_r8_inst0_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && res_cls == CL_INST0) |-> (grp == '0 && inst == '0 && !err));

  a_r9_err_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (hit && grp == '0 && inst == '0));

endmodule

bind steer_resolver steer_resolver_chk #(.ID_W(ID_W), .SS_PER_GRP(SS_PER_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .hit(hit), .err(err), .grp(grp), .inst(inst),
  .dflt_grp(dflt_grp), .dflt_inst(dflt_inst), .res_cls(res_cls), .walk_busy(walk_busy)
);

// File: tb/tb_steer_resolver.sv
module tb_steer_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] offset = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_cls = '0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [23:0] cfg_lo = '0, cfg_hi = '0;
  logic [2:0]  l3_fuse = 3'b111;
  logic [3:0]  mem_l3_en = 4'hF;
  logic [15:0] ss_en = 16'hFFFF;
  logic [7:0]  dflt_grp = 8'h5A, dflt_inst = 8'h3C;
  logic        done, hit, err;
  logic [7:0]  grp, inst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [23:0] m_lo [40];
  logic [23:0] m_hi [40];
  bit          m_v  [40];

  steer_resolver dut (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset),
    .cfg_we(cfg_we), .cfg_cls(cfg_cls), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .l3_fuse(l3_fuse), .mem_l3_en(mem_l3_en),
    .ss_en(ss_en), .dflt_grp(dflt_grp), .dflt_inst(dflt_inst),
    .done(done), .hit(hit), .grp(grp), .inst(inst), .err(err)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int c, input int e, input bit v, input logic [23:0] lo, input logic [23:0] hi);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cls = 3'(c); cfg_idx = 3'(e); cfg_valid = v; cfg_lo = lo; cfg_hi = hi;
    @(negedge clk);
    cfg_we = 1'b0;
    m_v[c*8+e] = v; m_lo[c*8+e] = lo; m_hi[c*8+e] = hi;
  endtask

  // Model of the class rules, restated from the requirements.
  task automatic model(input logic [23:0] off, output int lat, output bit h,
                       output int g, output int i, output bit e);
    int pos, cls, first;
    bit pres;
    pos = -1;
    for (int c = 0; c < 5; c++)
      for (int k = 0; k < 8; k++)
        if (pos < 0 && m_v[c*8+k] && m_lo[c*8+k] <= off && off <= m_hi[c*8+k]) pos = c*8+k;
    h = (pos >= 0); g = 0; i = 0; e = 0;
    if (!h) begin
      lat = 40; g = dflt_grp; i = dflt_inst;
      return;
    end
    lat = pos + 1;
    cls = pos / 8;
    first = -1;
    case (cls)
      0: begin
        for (int b = 0; b < 6; b++) if (first < 0 && l3_fuse[b/2]) first = b;
        if (first < 0) e = 1; else i = first;
      end
      1, 2: begin
        for (int m = 0; m < 4; m++) begin
          pres = mem_l3_en[m] || (ss_en[m*4 +: 4] != 4'h0);
          if (first < 0 && pres) first = m;
        end
        if (first < 0) e = 1; else g = (cls == 2) ? first * 2 : first;
      end
      3: begin
        for (int d = 0; d < 16; d++) if (first < 0 && ss_en[d]) first = d;
        if (first < 0) e = 1; else begin g = first / 4; i = first % 4; end
      end
      default: ;
    endcase
  endtask

  task automatic query(input logic [23:0] off, input string req);
    int elat, eg, ei, lat;
    bit eh, ee, got;
    model(off, elat, eh, eg, ei, ee);
    @(negedge clk);
    offset = off; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0; got = 0;
    while (!got && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (done) got = 1;
    end
    chk(lat == elat, req, "latency R10", lat, elat);
    chk(hit == eh, req, "hit", int'(hit), int'(eh));
    chk(int'(grp) == eg, req, "grp", int'(grp), eg);
    chk(int'(inst) == ei, req, "inst", int'(inst), ei);
    chk(err == ee, req, "err", int'(err), int'(ee));
  endtask

  task automatic t_reset();
    chk(done == 0 && hit == 0 && err == 0, "R12", "reset flags", int'({done, hit, err}), 0);
    chk(grp == 0 && inst == 0, "R12", "reset ids", int'({grp, inst}), 0);
    query(24'h001234, "R12 empty table");
    query(24'hFFFFFF, "R3 default");
  endtask

  task automatic t_l3_bounds();
    l3_fuse = 3'b110;
    cfg_write(0, 2, 1, 24'h00B100, 24'h00B3FF);
    query(24'h00B100, "R1 low edge R4");
    query(24'h00B3FF, "R1 high edge R4");
    query(24'h00B0FF, "R1 below");
    query(24'h00B400, "R1 above");
    l3_fuse = 3'b100;
    query(24'h00B200, "R4 bank pair 2");
  endtask

  task automatic t_priority();
    cfg_write(1, 0, 1, 24'h00B000, 24'h00B3FF);
    query(24'h00B200, "R2 class order");
    query(24'h00B050, "R2 second class");
    cfg_write(3, 5, 1, 24'h008000, 24'h0080FF);
    cfg_write(3, 1, 1, 24'h008080, 24'h0081FF);
    query(24'h0080A0, "R2 entry order");
  endtask

  task automatic t_slices();
    mem_l3_en = 4'b0000; ss_en = 16'h0200;
    cfg_write(2, 3, 1, 24'h00D800, 24'h00D8FF);
    query(24'h00B050, "R5 via subslice");
    query(24'h00D810, "R6 via subslice");
    mem_l3_en = 4'b0010;
    query(24'h00B050, "R5 via memory enable");
    query(24'h00D810, "R6 via memory enable");
  endtask

  task automatic t_subslice();
    ss_en = 16'h2000;
    query(24'h008000, "R7 d13");
    ss_en = 16'h0180;
    query(24'h008000, "R7 d7");
  endtask

  task automatic t_inst0();
    cfg_write(4, 7, 1, 24'h004000, 24'h004AFF);
    query(24'h004AFF, "R8 last entry");
    dflt_grp = 8'h07; dflt_inst = 8'h02;
    query(24'h004B00, "R3 new default");
  endtask

  task automatic t_empty();
    l3_fuse = 3'b000;
    query(24'h00B200, "R9 bank mask");
    mem_l3_en = 4'b0000; ss_en = 16'h0000;
    query(24'h00B050, "R9 slice mask");
    query(24'h00D810, "R9 lncf mask");
    query(24'h008000, "R9 subslice mask");
    l3_fuse = 3'b011; mem_l3_en = 4'b1000; ss_en = 16'h0010;
  endtask

  task automatic t_invalid();
    cfg_write(4, 0, 0, 24'h000000, 24'hFFFFFF);
    query(24'h123456, "R12 invalid entry");
    cfg_write(0, 2, 0, 24'h00B100, 24'h00B3FF);
    query(24'h00B200, "R12 cleared entry");
  endtask

  task automatic t_busy_start();
    int lat, n;
    bit got;
    @(negedge clk);
    offset = 24'h004A00; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; offset = 24'h00B050;
    lat = 0; got = 0;
    while (!got && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (lat == 5) start = 1'b1;
      if (lat == 6) start = 1'b0;
      if (done) got = 1;
    end
    chk(lat == 40, "R11", "latency kept", lat, 40);
    chk(hit == 1 && grp == 0 && inst == 0 && err == 0, "R11", "first offset result",
        int'({hit, grp, inst, err}), int'({1'b1, 16'h0, 1'b0}));
    n = 0;
    for (int k = 0; k < 50; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) n++;
    end
    chk(n == 0, "R11", "extra done pulses", n, 0);
  endtask

  task automatic t_hold();
    logic [7:0] g0, i0;
    bit same;
    query(24'h008000, "R10 held source");
    g0 = grp; i0 = inst;
    same = 1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done || grp != g0 || inst != i0 || !hit) same = 0;
    end
    chk(same, "R10", "outputs held", int'(same), 1);
  endtask

  initial begin
    for (int k = 0; k < 40; k++) begin m_v[k] = 0; m_lo[k] = '0; m_hi[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_l3_bounds();
    t_priority();
    t_slices();
    t_subslice();
    t_inst0();
    t_empty();
    t_invalid();
    t_busy_start();
    t_hold();
    finish_run();
  end

endmodule